// File: doc/BRIEF.md
# LIN Transmitter Fault Supervisor

This block watches over the transmit side of a LIN bus transceiver. It receives three fault indications from analog sensing: over-temperature of the output driver, a short on the receive pin, and overcurrent on the bus. It also receives the levels of the TXD and RXD pins. From these it decides whether the bus driver may be enabled. It keeps sticky status flags for the host and raises a level interrupt.

Each fault has its own rule for turning the driver back on:
- Over-temperature holds the driver off until the condition has cleared and TXD is high.
- A receive-pin short holds the driver off until the short has gone, an RXD transition has been seen, and TXD is high.
- A TXD line held dominant for longer than a tick-counted timeout holds the driver off until TXD goes high again.
- Overcurrent only records a flag.

Any detected fault also sets a receive-only control bit, which keeps the driver off until the host clears it. A host status read returns the flags and then clears each flag whose cause is gone at that moment. The host can also write the interrupt mask bit and the receive-only bit.

Top module: `lin_txfault_sup`

## Requirements
- R1: The fault inputs and RXD each pass through two synchronizing flops. A fault input that rises just before clock edge k takes effect at the outputs after edge k+2, and not after edge k+1.
- R2: A synchronized over-temperature fault sets status bit 0 and turns txen_o off. The over-temperature recovery machine releases the driver at the first edge where the fault is absent and txd_i is high.
- R3: A synchronized receive-pin short sets status bit 2 and turns txen_o off. Its recovery runs through three steps: the short must go away, a change of the synchronized RXD level must then be seen, and txd_i must then be high.
- R4: When txd_i stays low for TO_TICKS cycles in which tick_i is high, the driver turns off and status bit 3 is set. The driver is released at the first edge where txd_i is high. Any high level on txd_i restarts the count.
- R5: A synchronized overcurrent fault sets status bit 1. It does not hold the driver off by itself, so once receive-only is cleared, txen_o is high even while the overcurrent flag is still set.
- R6: A read strobe returns the current flags on host_rdata_o and then clears each flag whose cause is absent at that edge. Bits 0, 1 and 2 are cleared when their synchronized fault is low. Bit 3 is cleared when txd_i is high. A flag whose cause is still present survives the read.
- R7: irq_o is high exactly while the mask bit is set and at least one status flag is set.
- R8: Any fault detection sets the receive-only bit in the same edge that sets its flag, and this takes priority over a host write in the same cycle. While receive-only is set, txen_o is low.
- R9: A host write stores host_wdata_i bit 0 as the interrupt mask and bit 1 as the receive-only bit.
- R10: After reset, txen_o is high, irq_o and rxonly_o are low, host_rdata_o is zero and the mask is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Clock enable for the dominant timeout counter |
| txd_i | input | 1 | TXD level, synchronous to clk (0 = dominant) |
| rxd_i | input | 1 | RXD pin level, asynchronous |
| ot_flt_i | input | 1 | Driver over-temperature indication, asynchronous |
| rxs_flt_i | input | 1 | Receive-pin short indication, asynchronous |
| oc_flt_i | input | 1 | Bus overcurrent indication, asynchronous |
| host_rd_i | input | 1 | Status read strobe |
| host_wr_i | input | 1 | Control write strobe |
| host_wdata_i | input | 2 | Write data: bit 0 mask, bit 1 receive-only |
| host_rdata_o | output | 4 | Status flags: 0 over-temp, 1 overcurrent, 2 RX short, 3 TX dominant |
| txen_o | output | 1 | Bus driver enable |
| irq_o | output | 1 | Level interrupt request |
| rxonly_o | output | 1 | Current receive-only bit |

State machines:
- Over-temperature machine: OT_RUN, OT_HOLD. It moves OT_RUN→OT_HOLD on a fault, and OT_HOLD→OT_RUN when the fault is absent and TXD is high.
- Short machine: RS_OK, RS_SHORT, RS_WAIT_EDGE, RS_WAIT_TXH. Its transitions are:
  - Any state goes to RS_SHORT on a fault.
  - RS_SHORT goes to RS_WAIT_EDGE when the short goes away.
  - RS_WAIT_EDGE goes to RS_WAIT_TXH on an RXD edge.
  - RS_WAIT_TXH goes to RS_OK when TXD is high.
- Timeout machine: TD_IDLE, TD_COUNT, TD_STUCK. Its transitions are:
  - TD_IDLE goes to TD_COUNT when TXD is low.
  - TD_COUNT goes back to TD_IDLE when TXD is high.
  - TD_COUNT goes to TD_STUCK on the last tick.
  - TD_STUCK goes to TD_IDLE when TXD is high.

## Verification
Each fault is applied while TXD is high and again while TXD is low. This separates the over-temperature rule, which needs TXD high, from the overcurrent rule, which never blocks the driver. The receive-pin short is removed with RXD first held steady and then toggled, which shows that the edge step cannot be skipped. Status reads are issued both while a cause persists and after it has gone, which tells a guarded clear from an unconditional one. TXD is held low both for fewer ticks than the limit and for more, which checks the timeout boundary.

// File: rtl/lin_sup_pkg.sv
package lin_sup_pkg;

    typedef enum logic {
        OT_RUN,
        OT_HOLD
    } ot_state_t;

    typedef enum logic [1:0] {
        RS_OK,
        RS_SHORT,
        RS_WAIT_EDGE,
        RS_WAIT_TXH
    } rs_state_t;

    typedef enum logic [1:0] {
        TD_IDLE,
        TD_COUNT,
        TD_STUCK
    } td_state_t;

    localparam int FLAG_W   = 4;
    localparam int FL_OT    = 0;
    localparam int FL_OC    = 1;
    localparam int FL_RXS   = 2;
    localparam int FL_TDOM  = 3;

endpackage

// File: rtl/lin_sync.sv
module lin_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[g] <= RST_VAL[g];
                stage2[g] <= RST_VAL[g];
            end else begin
                stage1[g] <= d_i[g];
                stage2[g] <= stage1[g];
            end
        end
    end

    assign q_o = stage2;

endmodule

// File: rtl/lin_txdom_fsm.sv
module lin_txdom_fsm
    import lin_sup_pkg::*;
#(
    parameter int TO_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic txd_i,
    output logic stuck_o,
    output logic enter_o
);

    localparam int            CW   = (TO_TICKS > 1) ? $clog2(TO_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TO_TICKS - 1);

    td_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        enter_o = 1'b0;
        unique case (state_q)
            TD_IDLE: begin
                cnt_d = '0;
                if (!txd_i) state_d = TD_COUNT;
            end
            TD_COUNT: begin
                if (txd_i) begin
                    state_d = TD_IDLE;
                    cnt_d   = '0;
                end else if (tick_i) begin
                    if (cnt_q == LAST) begin
                        state_d = TD_STUCK;
                        enter_o = 1'b1;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            TD_STUCK: begin
                cnt_d = '0;
                if (txd_i) state_d = TD_IDLE;
            end
            default: begin
                state_d = TD_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign stuck_o = (state_q == TD_STUCK);

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        txd_i |=> !stuck_o);

endmodule

// File: rtl/lin_rxs_fsm.sv
module lin_rxs_fsm
    import lin_sup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic txd_i,
    input  logic short_i,
    input  logic rxd_edge_i,
    output logic blocked_o
);

    rs_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_OK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (short_i) begin
            state_d = RS_SHORT;
        end else begin
            unique case (state_q)
                RS_OK:        state_d = RS_OK;
                RS_SHORT:     state_d = RS_WAIT_EDGE;
                RS_WAIT_EDGE: if (rxd_edge_i) state_d = RS_WAIT_TXH;
                RS_WAIT_TXH:  if (txd_i) state_d = RS_OK;
                default:      state_d = RS_OK;
            endcase
        end
    end

    assign blocked_o = (state_q != RS_OK);

    a_r3_wait_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_WAIT_EDGE && !rxd_edge_i) |=> blocked_o);

    a_r3_short_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        short_i |=> blocked_o);

endmodule

// File: rtl/lin_txfault_sup.sv
module lin_txfault_sup
    import lin_sup_pkg::*;
#(
    parameter int TO_TICKS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       txd_i,
    input  logic       rxd_i,
    input  logic       ot_flt_i,
    input  logic       rxs_flt_i,
    input  logic       oc_flt_i,
    input  logic       host_rd_i,
    input  logic       host_wr_i,
    input  logic [1:0] host_wdata_i,
    output logic [3:0] host_rdata_o,
    output logic       txen_o,
    output logic       irq_o,
    output logic       rxonly_o
);

    localparam int SYNC_W = 4;

    // synchronized inputs: {rxd, oc, rxs, ot}
    logic [SYNC_W-1:0] sync_q;
    logic ot_s, rxs_s, oc_s, rxd_s, rxd_d;

    lin_sync #(.W(SYNC_W), .RST_VAL(4'b1000)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({rxd_i, oc_flt_i, rxs_flt_i, ot_flt_i}),
        .q_o   (sync_q)
    );

    assign ot_s  = sync_q[0];
    assign rxs_s = sync_q[1];
    assign oc_s  = sync_q[2];
    assign rxd_s = sync_q[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rxd_d <= 1'b1;
        else        rxd_d <= rxd_s;
    end

    // timeout and short recovery machines
    logic td_stuck, td_enter, rs_blocked;

    lin_txdom_fsm #(.TO_TICKS(TO_TICKS)) u_txdom (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .txd_i   (txd_i),
        .stuck_o (td_stuck),
        .enter_o (td_enter)
    );

    lin_rxs_fsm u_rxs (
        .clk        (clk),
        .rst_n      (rst_n),
        .txd_i      (txd_i),
        .short_i    (rxs_s),
        .rxd_edge_i (rxd_s ^ rxd_d),
        .blocked_o  (rs_blocked)
    );

    // over-temperature recovery machine
    ot_state_t ot_q, ot_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ot_q <= OT_RUN;
        else        ot_q <= ot_d;
    end

    always_comb begin
        ot_d = ot_q;
        unique case (ot_q)
            OT_RUN:  if (ot_s) ot_d = OT_HOLD;
            OT_HOLD: if (!ot_s && txd_i) ot_d = OT_RUN;
            default: ot_d = OT_RUN;
        endcase
    end

    // sticky flags with guarded read-clear
    logic [FLAG_W-1:0] flag_q, flag_d, cause_set, cause_live;

    always_comb begin
        cause_set           = '0;
        cause_set[FL_OT]    = ot_s;
        cause_set[FL_OC]    = oc_s;
        cause_set[FL_RXS]   = rxs_s;
        cause_set[FL_TDOM]  = td_enter;
        cause_live          = '0;
        cause_live[FL_OT]   = ot_s;
        cause_live[FL_OC]   = oc_s;
        cause_live[FL_RXS]  = rxs_s;
        cause_live[FL_TDOM] = !txd_i;
    end

    for (genvar f = 0; f < FLAG_W; f++) begin : g_flag
        always_comb begin
            if (cause_set[f])                      flag_d[f] = 1'b1;
            else if (host_rd_i && !cause_live[f])  flag_d[f] = 1'b0;
            else                                   flag_d[f] = flag_q[f];
        end
    end

    logic lin_err;
    logic mask_q, rxonly_q;

    assign lin_err = |cause_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q   <= '0;
            mask_q   <= 1'b0;
            rxonly_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
            if (host_wr_i) mask_q <= host_wdata_i[0];
            if (lin_err)        rxonly_q <= 1'b1;
            else if (host_wr_i) rxonly_q <= host_wdata_i[1];
        end
    end

    // outputs
    always_comb begin
        txen_o       = !rxonly_q && (ot_q == OT_RUN) && !rs_blocked && !td_stuck;
        irq_o        = mask_q && (|flag_q);
        rxonly_o     = rxonly_q;
        host_rdata_o = flag_q;
    end

    a_r2_ot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ot_s |=> !txen_o);

    a_r3_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && rxs_s) |=> host_rdata_o[FL_RXS]);

    a_r6_oc_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && oc_s) |=> host_rdata_o[FL_OC]);

    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q |-> !irq_o);

    a_r8_err_sets_rxonly: assert property (@(posedge clk) disable iff (!rst_n)
        lin_err |=> rxonly_o);

endmodule

// File: tb/lin_txfault_sup_tb_top.sv
module lin_txfault_sup_tb_top;

    localparam int CLK_P = 10;
    localparam int TO    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       txd_i = 1'b1, rxd_i = 1'b1;
    logic       ot_flt_i = 1'b0, rxs_flt_i = 1'b0, oc_flt_i = 1'b0;
    logic       host_rd_i = 1'b0, host_wr_i = 1'b0;
    logic [1:0] host_wdata_i = 2'b00;
    logic [3:0] host_rdata_o;
    logic       txen_o, irq_o, rxonly_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R10";
    bit cmp_en = 0;

    always #(CLK_P/2) clk = ~clk;

    lin_txfault_sup #(.TO_TICKS(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .txd_i(txd_i), .rxd_i(rxd_i),
        .ot_flt_i(ot_flt_i), .rxs_flt_i(rxs_flt_i), .oc_flt_i(oc_flt_i),
        .host_rd_i(host_rd_i), .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i),
        .host_rdata_o(host_rdata_o), .txen_o(txen_o), .irq_o(irq_o), .rxonly_o(rxonly_o)
    );

    // tick every fourth cycle
    int tick_cnt = 0;
    always @(negedge clk) begin
        tick_cnt = (tick_cnt + 1) % 4;
        tick_i  <= (tick_cnt == 0);
    end

    // behavioural reference model
    bit m_ot[2], m_rxs[2], m_oc[2], m_rxd[3];
    bit m_fot, m_foc, m_frxs, m_ftd, m_mask, m_rxonly, m_othold;
    int m_rsstep = 0;   // 0 fine, 1 shorted, 2 needs edge, 3 needs txd high
    int m_low_ticks = 0;
    bit m_stuck = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ot = '{0,0}; m_rxs = '{0,0}; m_oc = '{0,0}; m_rxd = '{1,1,1};
            {m_fot, m_foc, m_frxs, m_ftd, m_mask, m_rxonly, m_othold} = '0;
            m_rsstep = 0; m_low_ticks = 0; m_stuck = 0;
        end else begin
            bit ot, rxs, oc, edge_seen, hit;
            ot = m_ot[1]; rxs = m_rxs[1]; oc = m_oc[1];
            edge_seen = (m_rxd[1] != m_rxd[2]);
            hit = 0;
            if (txd_i) begin
                m_low_ticks = 0; m_stuck = 0;
            end else if (!m_stuck && tick_i) begin
                m_low_ticks++;
                if (m_low_ticks == TO) begin hit = 1; m_stuck = 1; m_low_ticks = 0; end
            end
            if (ot) m_othold = 1; else if (txd_i) m_othold = 0;
            if (rxs) m_rsstep = 1;
            else if (m_rsstep == 1) m_rsstep = 2;
            else if (m_rsstep == 2 && edge_seen) m_rsstep = 3;
            else if (m_rsstep == 3 && txd_i) m_rsstep = 0;
            if (ot) m_fot = 1; else if (host_rd_i) m_fot = 0;
            if (oc) m_foc = 1; else if (host_rd_i) m_foc = 0;
            if (rxs) m_frxs = 1; else if (host_rd_i) m_frxs = 0;
            if (hit) m_ftd = 1; else if (host_rd_i && txd_i) m_ftd = 0;
            if (host_wr_i) m_mask = host_wdata_i[0];
            if (ot || rxs || oc || hit) m_rxonly = 1;
            else if (host_wr_i) m_rxonly = host_wdata_i[1];
            m_rxd[2] = m_rxd[1]; m_rxd[1] = m_rxd[0]; m_rxd[0] = rxd_i;
            m_ot[1] = m_ot[0];   m_ot[0] = ot_flt_i;
            m_rxs[1] = m_rxs[0]; m_rxs[0] = rxs_flt_i;
            m_oc[1] = m_oc[0];   m_oc[0] = oc_flt_i;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            bit e_txen;
            e_txen = !m_rxonly && !m_othold && m_rsstep == 0 && !m_stuck;
            chk(cur_req, "model txen", txen_o, e_txen);
            chk("R7", "model irq", irq_o, m_mask && (m_fot|m_foc|m_frxs|m_ftd));
            chk("R8", "model rxonly", rxonly_o, m_rxonly);
            chk("R6", "model rdata", host_rdata_o, {m_ftd, m_frxs, m_foc, m_fot});
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(bit mask, bit rxo);
        host_wr_i = 1'b1; host_wdata_i = {rxo, mask};
        @(negedge clk);
        host_wr_i = 1'b0;
    endtask

    task automatic host_read();
        host_rd_i = 1'b1;
        @(negedge clk);
        host_rd_i = 1'b0;
    endtask

    initial begin
        #(CLK_P * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        cmp_en = 1;
        chk("R10", "reset txen", txen_o, 1);
        chk("R10", "reset irq", irq_o, 0);
        chk("R10", "reset rdata", host_rdata_o, 0);
        chk("R10", "reset rxonly", rxonly_o, 0);

        cur_req = "R9";
        host_write(1, 0);
        chk("R9", "mask only, no irq", irq_o, 0);

        // overcurrent: flag only
        cur_req = "R5";
        oc_flt_i = 1; cyc(5);
        chk("R5", "oc flag", host_rdata_o[1], 1);
        chk("R7", "irq with oc", irq_o, 1);
        host_read();
        chk("R6", "oc flag survives read", host_rdata_o[1], 1);
        oc_flt_i = 0; cyc(4);
        host_write(1, 0);
        chk("R5", "txen back with oc flag set", txen_o, 1);
        chk("R5", "oc flag still set", host_rdata_o[1], 1);
        host_read();
        chk("R6", "oc flag cleared", host_rdata_o[1], 0);
        chk("R7", "irq drops", irq_o, 0);

        // synchronizer latency
        cur_req = "R1";
        ot_flt_i = 1;
        cyc(2);
        chk("R1", "txen after two edges", txen_o, 1);
        cyc(1);
        chk("R1", "txen after three edges", txen_o, 0);

        // over-temperature
        cur_req = "R2";
        chk("R2", "ot flag", host_rdata_o[0], 1);
        host_read();
        chk("R6", "ot flag survives read", host_rdata_o[0], 1);
        txd_i = 0; ot_flt_i = 0; cyc(4);
        host_write(1, 0); cyc(2);
        chk("R2", "held while txd low", txen_o, 0);
        txd_i = 1; cyc(1);
        chk("R2", "released on txd high", txen_o, 1);
        host_read();
        chk("R6", "ot flag cleared", host_rdata_o[0], 0);

        // receive-pin short
        cur_req = "R3";
        rxs_flt_i = 1; cyc(5);
        chk("R3", "short blocks", txen_o, 0);
        chk("R3", "short flag", host_rdata_o[2], 1);
        rxs_flt_i = 0; cyc(4);
        host_write(1, 0); cyc(3);
        chk("R3", "held without rxd edge", txen_o, 0);
        rxd_i = 0; cyc(5);
        chk("R3", "released after edge", txen_o, 1);
        rxd_i = 1; cyc(4);
        host_read();
        chk("R6", "short flag cleared", host_rdata_o[2], 0);

        // dominant timeout
        cur_req = "R4";
        txd_i = 0; cyc(20);
        chk("R4", "short low no timeout", txen_o, 1);
        txd_i = 1; cyc(1);
        txd_i = 0; cyc(40);
        chk("R4", "timeout blocks", txen_o, 0);
        chk("R4", "tdom flag", host_rdata_o[3], 1);
        host_read();
        chk("R6", "tdom flag survives read", host_rdata_o[3], 1);
        txd_i = 1; cyc(1);
        host_write(1, 0);
        chk("R4", "released on txd high", txen_o, 1);
        host_read();
        chk("R6", "tdom flag cleared", host_rdata_o[3], 0);

        // receive-only and mask
        cur_req = "R8";
        host_write(1, 1);
        chk("R8", "rxonly set by host", rxonly_o, 1);
        chk("R8", "rxonly blocks txen", txen_o, 0);
        host_write(1, 0);
        chk("R8", "rxonly cleared", txen_o, 1);
        cur_req = "R7";
        host_write(0, 0);
        oc_flt_i = 1; cyc(5);
        chk("R7", "masked irq quiet", irq_o, 0);
        chk("R7", "flag set while masked", host_rdata_o[1], 1);
        oc_flt_i = 0; cyc(4);
        host_write(0, 0);
        chk("R8", "write clears rxonly after fault", rxonly_o, 0);
        host_read();
        cyc(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule